// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block sits between a request source and a byte-wide SPI master. It turns one high-level flash request into the full byte sequence for that request. A request carries a command code, a 24-bit address and a byte count. The block drives chip select low once for the whole request. It sends the opcode, then any address or dummy bytes, then clocks out 0x00 filler bytes to collect the response.

Each response byte is delivered on a one-cycle valid/data stream. Bytes received during the opcode, address and dummy phases are dropped. Chip select and the busy flag return high and low together, once the last byte of the request has completed.

The byte-wide master is driven through a simple handshake. The sequencer presents a transmit byte, waits for `xfer_ready`, and pulses `xfer_start` for one cycle. It then waits for `xfer_ready` again and takes `xfer_rx` as the received byte. The master is expected to drop `xfer_ready` at the clock edge that samples `xfer_start`.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `cs_n` is 1 and `busy`, `xfer_start` and `resp_valid` are 0.
- R2: Command code 0 (read) sends 0x03, then address bits [23:16], [15:8] and [7:0], then `req_len` filler bytes of 0x00. Each filler byte yields one response byte.
- R3: Command code 1 (status) sends 0x05 and two 0x00 fillers, and returns two response bytes.
- R4: Command code 2 (identification) sends 0x9F and three 0x00 fillers, and returns three response bytes.
- R5: Command code 3 (unique ID) sends 0x4B, four 0x00 dummy bytes and eight 0x00 fillers. Only the eight bytes received during the fillers are presented.
- R6: Command code 4 (write enable) sends the single byte 0x06 and presents no response.
- R7: Command code 5 (sector erase) sends 0x20 and the three address bytes, most significant first, and presents no response.
- R8: `cs_n` goes low in the cycle after a request is accepted and stays low across every byte of that request. It and `busy` return to 1 and 0 in the same cycle, after the last byte. `cs_n` is never low while `busy` is 0.
- R9: `xfer_start` is a one-cycle pulse, given only while `xfer_ready` is 1. The received byte is the value on `xfer_rx` when `xfer_ready` returns to 1. Response bytes are presented in the order they were received.
- R10: A request made while `busy` is 1 is refused: it sends no byte and leaves the running command unchanged.
- R11: Command codes 6 and 7 are ignored: `busy` stays 0, `cs_n` stays 1 and no byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_cmd | input | 3 | Command code |
| req_addr | input | 24 | Flash address |
| req_len | input | LEN_W | Number of data bytes for a read |
| busy | output | 1 | High from acceptance until chip select is released |
| cs_n | output | 1 | Flash chip select, active low |
| xfer_tx | output | 8 | Byte to send through the master |
| xfer_start | output | 1 | Start pulse to the master |
| xfer_ready | input | 1 | Master idle / byte complete |
| xfer_rx | input | 8 | Byte received by the master |
| resp_valid | output | 1 | Response byte strobe |
| resp_data | output | 8 | Response byte |

## Verification
Every command code is run against a behavioural byte-wide master. That master logs each transmitted byte and returns a distinct byte value per transfer. This separates the per-command framing, meaning opcode, address order and the number of dummy and filler bytes, from the choice of which received bytes reach the output stream.

Reads are tried with several lengths, including zero, and with different addresses. These runs show whether the address byte order and the filler count follow the request rather than a fixed value.

A second request is pulsed in the middle of a running command, to show that requests made while busy are refused. Out-of-range command codes are issued from idle, to show that they are ignored.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_cmd,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             cs_n,
  output logic [7:0]       xfer_tx,
  output logic             xfer_start,
  input  logic             xfer_ready,
  input  logic [7:0]       xfer_rx,
  output logic             resp_valid,
  output logic [7:0]       resp_data
);
  localparam int CW = LEN_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_PREP, S_GO, S_WAIT} st_t;
  st_t st;

  logic [2:0]    cmd_q;
  logic [23:0]   addr_q;
  logic [CW-1:0] idx, total_q, hdr_q;
  logic [CW-1:0] hdr_n, nresp_n;

  wire has_addr = (cmd_q == 3'd0) || (cmd_q == 3'd5);
  wire accept   = (st == S_IDLE) && req_valid && (req_cmd < 3'd6);

  always_comb begin
    case (req_cmd)
      3'd0:    begin hdr_n = CW'(4); nresp_n = CW'(req_len); end
      3'd1:    begin hdr_n = CW'(1); nresp_n = CW'(2); end
      3'd2:    begin hdr_n = CW'(1); nresp_n = CW'(3); end
      3'd3:    begin hdr_n = CW'(5); nresp_n = CW'(8); end
      3'd5:    begin hdr_n = CW'(4); nresp_n = '0; end
      default: begin hdr_n = CW'(1); nresp_n = '0; end
    endcase
  end

  always_comb begin
    xfer_tx = 8'h00;
    if (idx == '0) begin
      case (cmd_q)
        3'd0:    xfer_tx = 8'h03;
        3'd1:    xfer_tx = 8'h05;
        3'd2:    xfer_tx = 8'h9F;
        3'd3:    xfer_tx = 8'h4B;
        3'd4:    xfer_tx = 8'h06;
        default: xfer_tx = 8'h20;
      endcase
    end else if (has_addr && idx == CW'(1)) xfer_tx = addr_q[23:16];
    else if (has_addr && idx == CW'(2))     xfer_tx = addr_q[15:8];
    else if (has_addr && idx == CW'(3))     xfer_tx = addr_q[7:0];
  end

  assign xfer_start = (st == S_GO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      busy       <= 1'b0;
      cs_n       <= 1'b1;
      cmd_q      <= '0;
      addr_q     <= '0;
      idx        <= '0;
      total_q    <= '0;
      hdr_q      <= '0;
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          cmd_q   <= req_cmd;
          addr_q  <= req_addr;
          hdr_q   <= hdr_n;
          total_q <= hdr_n + nresp_n;
          idx     <= '0;
          busy    <= 1'b1;
          cs_n    <= 1'b0;
          st      <= S_PREP;
        end
        S_PREP: if (xfer_ready) st <= S_GO;
        S_GO:   st <= S_WAIT;
        S_WAIT: if (xfer_ready) begin
          if (idx >= hdr_q) begin
            resp_valid <= 1'b1;
            resp_data  <= xfer_rx;
          end
          if (idx == total_q - CW'(1)) begin
            st   <= S_IDLE;
            busy <= 1'b0;
            cs_n <= 1'b1;
          end else begin
            idx <= idx + CW'(1);
            st  <= S_PREP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_cmd,
  input logic       busy,
  input logic       cs_n,
  input logic       xfer_start,
  input logic       xfer_ready,
  input logic       resp_valid
);
  AST_START_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n) xfer_start |-> xfer_ready); // R9
  AST_START_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) xfer_start |=> !xfer_start); // R9
  AST_IDLE_CS_HIGH:     assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n); // R8
  AST_START_CS_LOW:     assert property (@(posedge clk) disable iff (!rst_n) xfer_start |-> !cs_n); // R8
  AST_ACCEPT:           assert property (@(posedge clk) disable iff (!rst_n)
                          (!busy && req_valid && req_cmd < 3'd6) |=> (busy && !cs_n)); // R8
  AST_BAD_CODE:         assert property (@(posedge clk) disable iff (!rst_n)
                          (!busy && req_valid && req_cmd >= 3'd6) |=> !busy); // R11
  AST_RESP_IN_FRAME:    assert property (@(posedge clk) disable iff (!rst_n)
                          resp_valid |-> $past(!cs_n)); // R2
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
  .busy(busy), .cs_n(cs_n), .xfer_start(xfer_start), .xfer_ready(xfer_ready),
  .resp_valid(resp_valid)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;
  localparam int DELAY = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_cmd = '0;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic busy, cs_n, xfer_start, resp_valid;
  logic [7:0] xfer_tx, resp_data;
  logic xfer_ready;
  logic [7:0] xfer_rx;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] sent_q[$], exp_rx[$];
  int cur_hdr = 0, done_in_frame = 0, byte_ctr = 0, cnt = 0, resp_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .cs_n(cs_n),
    .xfer_tx(xfer_tx), .xfer_start(xfer_start), .xfer_ready(xfer_ready),
    .xfer_rx(xfer_rx), .resp_valid(resp_valid), .resp_data(resp_data)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Behavioural byte-wide master
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_ready <= 1'b1;
      xfer_rx    <= 8'h00;
      cnt        <= 0;
    end else if (xfer_start) begin
      check(xfer_ready === 1'b1, "R9 start while not ready", xfer_ready, 1);
      check(cs_n === 1'b0, "R8 cs low at byte start", cs_n, 0);
      sent_q.push_back(xfer_tx);
      xfer_ready <= 1'b0;
      cnt <= DELAY;
    end else if (!xfer_ready) begin
      if (cnt == 0) begin
        logic [7:0] v;
        v = 8'(byte_ctr * 37 + 11);
        byte_ctr++;
        xfer_ready <= 1'b1;
        xfer_rx <= v;
        if (done_in_frame >= cur_hdr) exp_rx.push_back(v);
        done_in_frame++;
      end else cnt <= cnt - 1;
    end
  end

  // Per-clock reference comparison
  always @(negedge clk) if (rst_n) begin
    if (!busy) check(cs_n === 1'b1, "R8 cs high while idle", cs_n, 1);
    if (resp_valid) begin
      resp_cnt++;
      if (exp_rx.size() == 0) check(0, "R9 unexpected response byte", resp_data, 0);
      else begin
        logic [7:0] e;
        e = exp_rx.pop_front();
        check(resp_data === e, "R9 response byte order/value", resp_data, e);
      end
    end
  end

  task automatic run_cmd(input logic [2:0] c, input logic [23:0] a, input int len,
                         input bit interfere, input string req);
    logic [7:0] exp_tx[$];
    int nresp, w;
    case (c)
      3'd0: begin exp_tx = '{8'h03, a[23:16], a[15:8], a[7:0]}; nresp = len; end
      3'd1: begin exp_tx = '{8'h05}; nresp = 2; end
      3'd2: begin exp_tx = '{8'h9F}; nresp = 3; end
      3'd3: begin exp_tx = '{8'h4B, 8'h00, 8'h00, 8'h00, 8'h00}; nresp = 8; end
      3'd4: begin exp_tx = '{8'h06}; nresp = 0; end
      default: begin exp_tx = '{8'h20, a[23:16], a[15:8], a[7:0]}; nresp = 0; end
    endcase
    cur_hdr = exp_tx.size();
    for (int i = 0; i < nresp; i++) exp_tx.push_back(8'h00);
    sent_q.delete(); exp_rx.delete(); done_in_frame = 0; resp_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_addr = a; req_len = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    check(busy === 1'b1 && cs_n === 1'b0, {req, " R8 accept"}, {busy, cs_n}, 2'b10);
    if (interfere) begin
      repeat (6) @(negedge clk);
      req_valid = 1'b1; req_cmd = 3'd4; req_addr = 24'hFFFFFF;
      @(negedge clk);
      req_valid = 1'b0;
    end
    w = 0;
    while (busy === 1'b1 && w < 5000) begin
      if (cs_n !== 1'b0) check(0, {req, " R8 cs held low"}, cs_n, 0);
      @(negedge clk); w++;
    end
    check(cs_n === 1'b1, {req, " R8 release"}, cs_n, 1);
    check(sent_q.size() == exp_tx.size(), {req, " byte count"}, sent_q.size(), exp_tx.size());
    for (int i = 0; i < exp_tx.size() && i < sent_q.size(); i++)
      check(sent_q[i] === exp_tx[i], {req, " sent byte"}, sent_q[i], exp_tx[i]);
    repeat (4) @(negedge clk);
    check(resp_cnt == nresp, {req, " response count"}, resp_cnt, nresp);
    check(sent_q.size() == exp_tx.size() && busy === 1'b0, {req, " no extra frame"},
          sent_q.size(), exp_tx.size());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n === 1'b1 && busy === 1'b0 && xfer_start === 1'b0 && resp_valid === 1'b0,
          "R1 reset state", {cs_n, busy, xfer_start, resp_valid}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_cmd(3'd0, 24'h12A4C7, 5, 0, "R2 read5");
    run_cmd(3'd0, 24'hF00D01, 0, 0, "R2 read0");
    run_cmd(3'd0, 24'h000080, 1, 0, "R2 read1");
    run_cmd(3'd1, 24'h0, 0, 0, "R3 status");
    run_cmd(3'd2, 24'h0, 0, 0, "R4 jedec");
    run_cmd(3'd3, 24'h0, 0, 0, "R5 uid");
    run_cmd(3'd4, 24'h0, 0, 0, "R6 wren");
    run_cmd(3'd5, 24'hABCDEF, 0, 0, "R7 erase");
    run_cmd(3'd1, 24'h0, 0, 1, "R10 refuse busy");
    for (int c = 6; c < 8; c++) begin
      sent_q.delete();
      @(negedge clk);
      req_valid = 1'b1; req_cmd = 3'(c);
      @(negedge clk);
      req_valid = 1'b0;
      check(busy === 1'b0 && cs_n === 1'b1, "R11 code ignored", {busy, cs_n}, 2'b01);
      repeat (8) @(negedge clk);
      check(sent_q.size() == 0 && busy === 1'b0, "R11 no byte sent", sent_q.size(), 0);
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule